// File: doc/BRIEF.md
# Counter Access Permission Gate

This block decides whether a read of one of the user-visible counter CSRs may go ahead at the current privilege level. It holds two 32-bit enable registers. The machine-level register grants access to the mode just below machine mode. The supervisor-level register, when supervisor mode exists, further narrows what user mode may read. Each request carries a privilege mode and a 12-bit CSR address. The block answers in the same cycle with either an allow flag or an illegal-instruction flag.

Software writes the enable registers through two write strobes that share one data bus. A parameter mask marks enable bits as hardwired to zero. Those bits always read 0 and ignore writes. Another parameter states whether supervisor mode is implemented.

Stub counters for cycle, time and retired instructions sit beside the gate. They show that changing permissions never disturbs the counters. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `ctr_access_gate`

## Requirements
- R1: After reset is released, both enable registers read 0. Every counter read from supervisor (priv 2'b01) or user (priv 2'b00) mode is flagged illegal.
- R2: From machine mode (priv 2'b11), every counter read is allowed, whatever the enable registers hold.
- R3: From supervisor mode, a counter read is allowed exactly when the machine-level enable bit at the decoded index is 1. Otherwise it is illegal.
- R4: With supervisor mode implemented, a user-mode counter read is allowed only when both the machine-level bit and the supervisor-level bit at the index are 1.
- R5: With supervisor mode not implemented, a user-mode read depends on the machine-level bit alone. In that configuration supervisor mode is denied, and the supervisor-level register reads 0 and ignores writes.
- R6: Enable bits set in the hardwired mask read 0 whatever is written. Lower-mode reads of the matching counters are illegal.
- R7: Counter addresses are 0xC00..0xC1F (low halves) and 0xC80..0xC9F (high halves). Both ranges select enable bit addr[4:0], with bit 0 for cycle, bit 1 for time, bit 2 for instret and bits 3..31 for the event counters. For any other address, or with no request, both flags stay 0.
- R8: The flags follow the request combinationally. A write to an enable register shows up in the readback and in the flags from the next rising clock edge, and not before.
- R9: The cycle counter adds 1 every clock, the instret counter adds 1 on each clock with retire_i high, and the time counter adds 1 on each clock with tick_i high. Enable-register writes never change these counts.
- R10: The reserved privilege encoding 2'b10 is treated as denied: every counter read from it is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege (U=00, S=01, M=11) |
| rd_req_i | input | 1 | CSR read request valid |
| rd_addr_i | input | 12 | CSR read address |
| m_wr_i | input | 1 | Write strobe, machine-level enable register |
| s_wr_i | input | 1 | Write strobe, supervisor-level enable register |
| wr_data_i | input | 32 | Write data for the enable registers |
| retire_i | input | 1 | One instruction retired this cycle |
| tick_i | input | 1 | Time-base tick |
| allow_o | output | 1 | Counter read permitted |
| illegal_o | output | 1 | Counter read raises illegal instruction |
| m_en_o | output | 32 | Machine-level enable register value |
| s_en_o | output | 32 | Supervisor-level enable register value |
| cycle_o | output | 64 | Cycle counter stub |
| time_o | output | 64 | Time counter stub |
| instret_o | output | 64 | Retired-instruction counter stub |

## Verification
The permission flags have zero latency, so the bench drives a request at the falling edge and samples the flags one nanosecond later. At that point its model still holds the register values from before any write driven in the same cycle. Enable-register writes and counter increments are due one rising edge later, so the bench updates its model only after that edge and compares readbacks and counts at the next falling edge. Reset release passes through two synchronising flops, and the bench waits out those two cycles before its first check.

// File: rtl/ctr_acc_pkg.sv
package ctr_acc_pkg;
  localparam int unsigned EN_W = 32;
  localparam int unsigned IDX_W = $clog2(EN_W);

  typedef enum logic [1:0] {
    PRV_U   = 2'b00,
    PRV_S   = 2'b01,
    PRV_RSV = 2'b10,
    PRV_M   = 2'b11
  } priv_e;
endpackage

// File: rtl/ctr_en_reg.sv
module ctr_en_reg
  import ctr_acc_pkg::*;
#(
  parameter logic [EN_W-1:0] HARD_ZERO = '0,
  parameter bit              PRESENT   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [EN_W-1:0] wdata_i,
  output logic [EN_W-1:0] q_o
);
  localparam logic [EN_W-1:0] KEEP = PRESENT ? ~HARD_ZERO : '0;

  logic [EN_W-1:0] q_d, q_r;

  always_comb begin
    q_d = q_r;
    if (wr_i) q_d = wdata_i & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (wr_i) q_r <= q_d;
  end

  assign q_o = q_r;

  // R6
  hardwired_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r & ~KEEP) == '0);

  // R8
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_r));
endmodule

// File: rtl/ctr_addr_dec.sv
module ctr_addr_dec
  import ctr_acc_pkg::*;
(
  input  logic [11:0]      addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = (addr_i[11:8] == 4'hC) &&
            ((addr_i[7:5] == 3'b000) || (addr_i[7:5] == 3'b100));
    idx_o = addr_i[IDX_W-1:0];
  end
endmodule

// File: rtl/ctr_perm.sv
module ctr_perm
  import ctr_acc_pkg::*;
#(
  parameter bit S_IMPL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv_i,
  input  logic             req_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [EN_W-1:0]  m_en_i,
  input  logic [EN_W-1:0]  s_en_i,
  output logic             allow_o,
  output logic             illegal_o
);
  logic m_bit, s_bit, grant;

  always_comb begin
    m_bit = m_en_i[idx_i];
    s_bit = s_en_i[idx_i];
    grant = 1'b0;
    unique case (priv_e'(priv_i))
      PRV_M:   grant = 1'b1;
      PRV_S:   grant = S_IMPL && m_bit;
      PRV_U:   grant = S_IMPL ? (m_bit && s_bit) : m_bit;
      default: grant = 1'b0;
    endcase
    allow_o   = req_i && hit_i && grant;
    illegal_o = req_i && hit_i && !grant;
  end

  // R2
  machine_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && hit_i && priv_i == 2'b11) |-> allow_o);

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({allow_o, illegal_o}));

  // R7
  no_request_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && hit_i) |-> !(allow_o || illegal_o));

  // R10
  reserved_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b10) |-> !allow_o);
endmodule

// File: rtl/ctr_stub_counters.sv
module ctr_stub_counters #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cycle_o,
  output logic [CNT_W-1:0] time_o,
  output logic [CNT_W-1:0] instret_o
);
  logic [CNT_W-1:0] cyc_r, cyc_d, tim_r, tim_d, ret_r, ret_d;

  always_comb begin
    cyc_d = cyc_r + 1'b1;
    tim_d = tim_r + 1'b1;
    ret_d = ret_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_r <= '0;
      tim_r <= '0;
      ret_r <= '0;
    end else begin
      cyc_r <= cyc_d;
      if (tick_i)   tim_r <= tim_d;
      if (retire_i) ret_r <= ret_d;
    end
  end

  assign cycle_o   = cyc_r;
  assign time_o    = tim_r;
  assign instret_o = ret_r;

  // R9
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc_r == $past(cyc_r) + 1'b1);

  // R9
  instret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> $stable(ret_r));
endmodule

// File: rtl/ctr_access_gate.sv
module ctr_access_gate
  import ctr_acc_pkg::*;
#(
  parameter logic [31:0] HARD_ZERO = 32'hC000_0000,
  parameter bit          S_IMPL    = 1'b1,
  parameter int unsigned CNT_W     = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv_i,
  input  logic             rd_req_i,
  input  logic [11:0]      rd_addr_i,
  input  logic             m_wr_i,
  input  logic             s_wr_i,
  input  logic [31:0]      wr_data_i,
  input  logic             retire_i,
  input  logic             tick_i,
  output logic             allow_o,
  output logic             illegal_o,
  output logic [31:0]      m_en_o,
  output logic [31:0]      s_en_o,
  output logic [CNT_W-1:0] cycle_o,
  output logic [CNT_W-1:0] time_o,
  output logic [CNT_W-1:0] instret_o
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [EN_W-1:0]  m_en, s_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ctr_en_reg #(.HARD_ZERO(HARD_ZERO), .PRESENT(1'b1)) u_m_en (
    .clk(clk), .rst_n(rst_int_n), .wr_i(m_wr_i), .wdata_i(wr_data_i), .q_o(m_en)
  );

  ctr_en_reg #(.HARD_ZERO(HARD_ZERO), .PRESENT(S_IMPL)) u_s_en (
    .clk(clk), .rst_n(rst_int_n), .wr_i(s_wr_i), .wdata_i(wr_data_i), .q_o(s_en)
  );

  ctr_addr_dec u_dec (.addr_i(rd_addr_i), .hit_o(hit), .idx_o(idx));

  ctr_perm #(.S_IMPL(S_IMPL)) u_perm (
    .clk(clk), .rst_n(rst_int_n), .priv_i(priv_i), .req_i(rd_req_i),
    .hit_i(hit), .idx_i(idx), .m_en_i(m_en), .s_en_i(s_en),
    .allow_o(allow_o), .illegal_o(illegal_o)
  );

  ctr_stub_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .retire_i(retire_i), .tick_i(tick_i),
    .cycle_o(cycle_o), .time_o(time_o), .instret_o(instret_o)
  );

  assign m_en_o = m_en;
  assign s_en_o = s_en;

  // R4
  user_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (S_IMPL && allow_o && priv_i == 2'b00) |-> (m_en[idx] && s_en[idx]));

  // R3
  super_needs_m_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (allow_o && priv_i == 2'b01) |-> m_en[idx]);
endmodule

// File: tb/ctr_access_gate_test.sv
module ctr_access_gate_test;
  localparam logic [31:0] MASK_T = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  priv;
  logic        req, m_wr, s_wr, retire, tick;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        allow_a, illegal_a, allow_b, illegal_b;
  logic [31:0] men_a, sen_a, men_b, sen_b;
  logic [63:0] cyc_a, tim_a, ret_a, cyc_b, tim_b, ret_b;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_mod, s_mod, m_mod_b;
  logic [63:0] cyc_prev, tim_exp, ret_exp;
  bit          cyc_valid;

  always #4 clk = ~clk;

  ctr_access_gate #(.HARD_ZERO(MASK_T), .S_IMPL(1'b1), .CNT_W(64)) uut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .rd_req_i(req), .rd_addr_i(addr),
    .m_wr_i(m_wr), .s_wr_i(s_wr), .wr_data_i(wdata), .retire_i(retire),
    .tick_i(tick), .allow_o(allow_a), .illegal_o(illegal_a), .m_en_o(men_a),
    .s_en_o(sen_a), .cycle_o(cyc_a), .time_o(tim_a), .instret_o(ret_a)
  );

  ctr_access_gate #(.HARD_ZERO(MASK_T), .S_IMPL(1'b0), .CNT_W(64)) uut_nos (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .rd_req_i(req), .rd_addr_i(addr),
    .m_wr_i(m_wr), .s_wr_i(s_wr), .wr_data_i(wdata), .retire_i(retire),
    .tick_i(tick), .allow_o(allow_b), .illegal_o(illegal_b), .m_en_o(men_b),
    .s_en_o(sen_b), .cycle_o(cyc_b), .time_o(tim_b), .instret_o(ret_b)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic bit is_ctr(input logic [11:0] a);
    return (a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F);
  endfunction

  // expected allow per R2..R5, R7, R10
  function automatic bit exp_allow(input logic [1:0] p, input logic r,
                                   input logic [11:0] a, input logic [31:0] m,
                                   input logic [31:0] s, input bit simpl);
    int i;
    i = int'(a[4:0]);
    if (!r || !is_ctr(a)) return 1'b0;
    case (p)
      2'b11:   return 1'b1;
      2'b01:   return simpl && m[i];
      2'b00:   return simpl ? (m[i] && s[i]) : m[i];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_illegal(input logic [1:0] p, input logic r,
                                     input logic [11:0] a, input logic [31:0] m,
                                     input logic [31:0] s, input bit simpl);
    return r && is_ctr(a) && !exp_allow(p, r, a, m, s, simpl);
  endfunction

  // one cycle: drive at falling edge, check flags 1 ns later, registers after next edge
  task automatic step(input logic [1:0] p, input logic r, input logic [11:0] a,
                      input logic mw, input logic sw, input logic [31:0] d,
                      input logic rt, input logic tk, input string tag);
    @(negedge clk);
    priv = p; req = r; addr = a; m_wr = mw; s_wr = sw; wdata = d;
    retire = rt; tick = tk;
    #1;
    chk(allow_a == exp_allow(p, r, a, m_mod, s_mod, 1'b1), tag, 64'(allow_a),
        64'(exp_allow(p, r, a, m_mod, s_mod, 1'b1)));
    chk(illegal_a == exp_illegal(p, r, a, m_mod, s_mod, 1'b1), tag, 64'(illegal_a),
        64'(exp_illegal(p, r, a, m_mod, s_mod, 1'b1)));
    chk(allow_b == exp_allow(p, r, a, m_mod_b, 32'h0, 1'b0), {tag, " R5"},
        64'(allow_b), 64'(exp_allow(p, r, a, m_mod_b, 32'h0, 1'b0)));
    chk(illegal_b == exp_illegal(p, r, a, m_mod_b, 32'h0, 1'b0), {tag, " R5"},
        64'(illegal_b), 64'(exp_illegal(p, r, a, m_mod_b, 32'h0, 1'b0)));
    chk(men_a == m_mod, "R8 m readback", 64'(men_a), 64'(m_mod));
    chk(sen_a == s_mod, "R8 s readback", 64'(sen_a), 64'(s_mod));
    chk(sen_b == 32'h0, "R5 s reads zero", 64'(sen_b), 64'h0);
    if (cyc_valid) chk(cyc_a == cyc_prev + 64'd1, "R9 cycle", cyc_a, cyc_prev + 64'd1);
    chk(ret_a == ret_exp, "R9 instret", ret_a, ret_exp);
    chk(tim_a == tim_exp, "R9 time", tim_a, tim_exp);
    cyc_prev = cyc_a;
    cyc_valid = 1'b1;
    @(posedge clk);
    if (mw) begin
      m_mod   = d & ~MASK_T;
      m_mod_b = d & ~MASK_T;
    end
    if (sw) s_mod = d & ~MASK_T;
    if (rt) ret_exp = ret_exp + 64'd1;
    if (tk) tim_exp = tim_exp + 64'd1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [11:0] ra;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    rst_n = 1'b0; priv = 2'b00; req = 1'b0; addr = '0; m_wr = 1'b0; s_wr = 1'b0;
    wdata = '0; retire = 1'b0; tick = 1'b0;
    m_mod = '0; s_mod = '0; m_mod_b = '0; tim_exp = '0; ret_exp = '0;
    cyc_prev = '0; cyc_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(men_a == 32'h0, "R1 m reset", 64'(men_a), 64'h0);
    chk(sen_a == 32'h0, "R1 s reset", 64'(sen_a), 64'h0);
    step(2'b01, 1'b1, 12'hC00, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 S read after reset");
    step(2'b00, 1'b1, 12'hC82, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 U read after reset");
    // R2: machine always
    step(2'b11, 1'b1, 12'hC1F, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 M read");
    // R8: write M enables; same cycle still old value
    step(2'b01, 1'b1, 12'hC01, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R8 same cycle");
    step(2'b01, 1'b1, 12'hC01, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R3 S after enable");
    // R6: hardwired bits
    chk(men_a == ~MASK_T, "R6 mask readback", 64'(men_a), 64'(~MASK_T));
    step(2'b01, 1'b1, 12'hC1F, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 S HPM31 illegal");
    step(2'b01, 1'b1, 12'hC9E, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 S HPM30h illegal");
    // R4: U needs supervisor bit too
    step(2'b00, 1'b1, 12'hC02, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4 U no s bit");
    step(2'b00, 1'b1, 12'hC02, 1'b0, 1'b1, 32'h0000_0004, 1'b0, 1'b0, "R4 s write");
    step(2'b00, 1'b1, 12'hC82, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4 U both bits");
    step(2'b00, 1'b1, 12'hC03, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4 U other bit");
    // R7: address map edges
    step(2'b11, 1'b1, 12'hC20, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 C20 no hit");
    step(2'b11, 1'b1, 12'hC7F, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 C7F no hit");
    step(2'b11, 1'b1, 12'hCA0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 CA0 no hit");
    step(2'b00, 1'b1, 12'hB00, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 B00 no hit");
    step(2'b00, 1'b0, 12'hC02, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 no request");
    // R10: reserved privilege
    step(2'b10, 1'b1, 12'hC00, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 reserved");
    // R5: writes to the missing supervisor register are ignored
    step(2'b00, 1'b1, 12'hC05, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 s write");
    step(2'b00, 1'b1, 12'hC05, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 U after s write");
    // clear M enables
    step(2'b01, 1'b1, 12'hC00, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, "R8 clear write");
    step(2'b01, 1'b1, 12'hC00, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R3 S after clear");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] p;
      logic [31:0] rv;
      rv = $urandom;
      case (rv[1:0])
        2'd0: p = 2'b00;
        2'd1: p = 2'b01;
        2'd2: p = 2'b11;
        default: p = rv[2] ? 2'b10 : 2'b00;
      endcase
      case (rv[4:3])
        2'd0: ra = {7'b1100_000, rv[9:5]};
        2'd1: ra = {7'b1100_100, rv[9:5]};
        default: ra = rv[21:10];
      endcase
      step(p, rv[22], ra, rv[23] & rv[24], rv[25] & rv[26], $urandom,
           rv[27], rv[28], "R3 R4 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule